// File: doc/BRIEF.md
# Switch Matrix Change Capture

This block sits in a bus slave between the switch-matrix scanner and the path that answers the bus master. Each scan delivers a vector of switch states with a valid strobe, one strobe per message slot. The block keeps a reference, which is the value last handed to the master. When capture is enabled, it freezes the first scan that differs from that reference until the master reads the matrix. The master therefore sees a short switch closure even if the switch has opened again before the read.

A separate enable bit turns on local wake-up. With it set, a change on any matrix input raises a one-cycle wake request. The request is then disarmed until the next read or until a sleep re-entry rearms it. When both enables are set, the frozen value is the scan that caused the wake-up, so the master can identify the switch responsible. After reset, the master must read twice before change detection starts. The first read establishes the reference.

Top module: `swm_capture_top`

## Requirements
- R1: After reset, `reportValue` is all zeros and both `pending` and `wakeReq` are 0.
- R2: Until two `readStb` pulses have been seen since reset, no scan sets `pending` or raises `wakeReq`, and `reportValue` equals the latest sampled scan.
- R3: `scanData` is sampled only in cycles where `scanValid` is 1. A scan cycle without the strobe leaves `reportValue` unchanged.
- R4: With `capEn` = 1, a strobed scan that differs from the reference sets `pending` and shows that scan on `reportValue` in the cycle after the strobe. Later scans leave `reportValue` unchanged until a read.
- R5: A read clears `pending` and makes the latest sampled scan the reference. If a differing scan is strobed in the same cycle as the read, `pending` stays set and `reportValue` shows the new scan.
- R6: With `capEn` = 0, `pending` is 0 and `reportValue` equals the latest sampled scan.
- R7: With `wakeEn` = 1 and wake armed, a strobed scan that differs from the reference drives `wakeReq` high for exactly the one cycle after the strobe.
- R8: After a wake request, further changes raise no request until a `readStb` or `sleepEnter` pulse rearms it.
- R9: With `wakeEn` = 0, `wakeReq` stays 0.
- R10: With both enables set, `reportValue` after a wake request equals the scan that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| scanValid | input | 1 | Strobe: a fresh matrix scan is present on `scanData` |
| scanData | input | W | Scanned switch states, one bit per matrix position |
| capEn | input | 1 | Enables change capture |
| wakeEn | input | 1 | Enables local wake-up on change |
| readStb | input | 1 | Master read of the matrix value |
| sleepEnter | input | 1 | Sleep re-entry; rearms wake-up |
| reportValue | output | W | Matrix value returned to the master |
| pending | output | 1 | A captured change is waiting to be read |
| wakeReq | output | 1 | One-cycle local wake-up request |

## Verification
The bench builds the block with a matrix width of 4, so 16 switch codes are possible. It walks every ordered pair of reference and next scan, then applies a follow-up scan that always differs. This covers freezing, wake disarming, and the equal-value case, where no change may be flagged, for every code. The same small width allows a full sweep of the transparent mode with capture off. It also allows directed runs of the two-read start-up, a read colliding with a scan, and sleep rearming.

// File: rtl/swm_pkg.sv
package swm_pkg;

  typedef struct packed {
    logic loadSample;
    logic loadRef;
    logic loadHeld;
    logic refFromSample;
    logic showHeld;
  } swmCtrl_t;

  localparam int unsigned INIT_READS = 2;

endpackage

// File: rtl/swm_datapath.sv
module swm_datapath #(
  parameter int unsigned W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  swm_pkg::swmCtrl_t    ctrl,
  input  logic [W-1:0]         scanData,
  output logic                 changeDet,
  output logic [W-1:0]         reportValue
);

  logic [W-1:0] sampleReg;
  logic [W-1:0] refReg;
  logic [W-1:0] heldReg;
  logic [W-1:0] effRef;
  logic [W-1:0] bitDiff;

  assign effRef = ctrl.refFromSample ? sampleReg : refReg;

  for (genvar i = 0; i < W; i++) begin : gDiff
    assign bitDiff[i] = scanData[i] ^ effRef[i];
  end

  assign changeDet = |bitDiff;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleReg <= '0;
      refReg    <= '0;
      heldReg   <= '0;
    end else begin
      if (ctrl.loadSample) sampleReg <= scanData;
      if (ctrl.loadRef)    refReg    <= sampleReg;
      if (ctrl.loadHeld)   heldReg   <= scanData;
    end
  end

  assign reportValue = ctrl.showHeld ? heldReg : sampleReg;

endmodule

// File: rtl/swm_control.sv
module swm_control (
  input  logic              clk,
  input  logic              rstN,
  input  logic              scanValid,
  input  logic              readStb,
  input  logic              sleepEnter,
  input  logic              capEn,
  input  logic              wakeEn,
  input  logic              changeDet,
  output swm_pkg::swmCtrl_t ctrl,
  output logic              pending,
  output logic              wakeReq
);

  localparam int unsigned CW = $clog2(swm_pkg::INIT_READS + 1);

  logic [CW-1:0] initCnt;
  logic          initDone;
  logic          wakeArmed;
  logic          hit;
  logic          capture;
  logic          fire;

  assign initDone = (initCnt == CW'(swm_pkg::INIT_READS));
  assign hit      = scanValid && changeDet && initDone;
  assign capture  = capEn && hit && (!pending || readStb);
  assign fire     = hit && wakeEn && wakeArmed;

  always_comb begin
    ctrl               = '0;
    ctrl.loadSample    = scanValid;
    ctrl.loadRef       = readStb;
    ctrl.loadHeld      = capture;
    ctrl.refFromSample = readStb;
    ctrl.showHeld      = capEn && pending;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initCnt <= '0;
    end else if (readStb && !initDone) begin
      initCnt <= initCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
    end else if (!capEn) begin
      pending <= 1'b0;
    end else if (capture) begin
      pending <= 1'b1;
    end else if (readStb) begin
      pending <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeReq   <= 1'b0;
      wakeArmed <= 1'b1;
    end else begin
      wakeReq <= fire;
      if (fire) begin
        wakeArmed <= 1'b0;
      end else if (readStb || sleepEnter) begin
        wakeArmed <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/swm_capture_top.sv
module swm_capture_top #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         scanValid,
  input  logic [W-1:0] scanData,
  input  logic         capEn,
  input  logic         wakeEn,
  input  logic         readStb,
  input  logic         sleepEnter,
  output logic [W-1:0] reportValue,
  output logic         pending,
  output logic         wakeReq
);

  swm_pkg::swmCtrl_t ctrl;
  logic              changeDet;

  swm_control uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .scanValid  (scanValid),
    .readStb    (readStb),
    .sleepEnter (sleepEnter),
    .capEn      (capEn),
    .wakeEn     (wakeEn),
    .changeDet  (changeDet),
    .ctrl       (ctrl),
    .pending    (pending),
    .wakeReq    (wakeReq)
  );

  swm_datapath #(.W(W)) uData (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .scanData    (scanData),
    .changeDet   (changeDet),
    .reportValue (reportValue)
  );

endmodule

// File: rtl/swm_capture_chk.sv
module swm_capture_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rstN,
  input logic         scanValid,
  input logic [W-1:0] scanData,
  input logic         capEn,
  input logic         wakeEn,
  input logic         readStb,
  input logic [W-1:0] reportValue,
  input logic         pending,
  input logic         wakeReq
);

  logic [1:0]   readsSeen;
  logic [W-1:0] lastScan;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readsSeen <= '0;
      lastScan  <= '0;
    end else begin
      if (readStb && readsSeen != 2'd2) readsSeen <= readsSeen + 1'b1;
      if (scanValid) lastScan <= scanData;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) !rstN |-> (!pending && !wakeReq)); // R1
  AST_NO_EARLY_DETECT: assert property (@(posedge clk) disable iff (!rstN)
    (readsSeen != 2'd2) |-> (!pending && !wakeReq)); // R2
  AST_HELD_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (pending && capEn && !readStb) |=> (!capEn || reportValue == $past(reportValue))); // R4
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (readStb && !scanValid) |=> !pending); // R5
  AST_CAP_OFF_TRANSPARENT: assert property (@(posedge clk) disable iff (!rstN)
    !capEn |-> (reportValue == lastScan)); // R6
  AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |=> !wakeReq); // R7
  AST_WAKE_NEEDS_SCAN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wakeReq) |-> $past(scanValid)); // R7
  AST_WAKE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !wakeEn |=> !wakeReq); // R9

endmodule

bind swm_capture_top swm_capture_chk #(.W(W)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .scanValid   (scanValid),
  .scanData    (scanData),
  .capEn       (capEn),
  .wakeEn      (wakeEn),
  .readStb     (readStb),
  .reportValue (reportValue),
  .pending     (pending),
  .wakeReq     (wakeReq)
);

// File: tb/tb_swm_capture_top.sv
module tb_swm_capture_top;

  localparam int unsigned W = 4;
  localparam int unsigned NV = 1 << W;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         scanValid = 1'b0;
  logic [W-1:0] scanData = '0;
  logic         capEn = 1'b0;
  logic         wakeEn = 1'b0;
  logic         readStb = 1'b0;
  logic         sleepEnter = 1'b0;
  logic [W-1:0] reportValue;
  logic         pending;
  logic         wakeReq;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  swm_capture_top #(.W(W)) dut (
    .clk(clk), .rstN(rstN), .scanValid(scanValid), .scanData(scanData),
    .capEn(capEn), .wakeEn(wakeEn), .readStb(readStb), .sleepEnter(sleepEnter),
    .reportValue(reportValue), .pending(pending), .wakeReq(wakeReq)
  );

  task automatic checkEq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input logic v, input logic [W-1:0] d, input logic rd, input logic slp);
    @(negedge clk);
    scanValid = v; scanData = d; readStb = rd; sleepEnter = slp;
    @(negedge clk);
    scanValid = 1'b0; readStb = 1'b0; sleepEnter = 1'b0;
  endtask

  task automatic scan(input logic [W-1:0] d);
    cyc(1'b1, d, 1'b0, 1'b0);
  endtask

  task automatic rd();
    cyc(1'b0, '0, 1'b1, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    capEn = 1'b1; wakeEn = 1'b1;
    repeat (3) @(negedge clk);
    checkEq("R1", "report", int'(reportValue), 0);
    checkEq("R1", "pending", int'(pending), 0);
    checkEq("R1", "wake", int'(wakeReq), 0);
    rstN = 1'b1;

    // R2: start-up needs two reads
    scan(4'd5);
    checkEq("R2", "pending", int'(pending), 0);
    checkEq("R2", "wake", int'(wakeReq), 0);
    checkEq("R2", "report", int'(reportValue), 5);
    rd();
    scan(4'd9);
    checkEq("R2", "pending after 1 read", int'(pending), 0);
    checkEq("R2", "wake after 1 read", int'(wakeReq), 0);
    checkEq("R2", "report", int'(reportValue), 9);
    rd();
    scan(4'd3);
    checkEq("R4", "pending after init", int'(pending), 1);
    checkEq("R7", "wake after init", int'(wakeReq), 1);
    checkEq("R10", "wake source", int'(reportValue), 3);
    @(negedge clk);
    checkEq("R7", "wake one cycle", int'(wakeReq), 0);

    // R3: data without strobe ignored
    rd();
    cyc(1'b0, 4'd12, 1'b0, 1'b0);
    checkEq("R3", "unstrobed report", int'(reportValue), 3);
    checkEq("R3", "unstrobed pending", int'(pending), 0);

    // exhaustive pair sweep, both enables on
    for (int a = 0; a < NV; a++) begin
      for (int b = 0; b < NV; b++) begin
        int c;
        bit chg;
        c = b ^ 1;
        chg = (a != b);
        scan(W'(a));
        rd();
        checkEq("R5", "pending after read", int'(pending), 0);
        checkEq("R5", "report after read", int'(reportValue), a);
        scan(W'(b));
        checkEq("R4", "pending on b", int'(pending), int'(chg));
        checkEq("R7", "wake on b", int'(wakeReq), int'(chg));
        checkEq("R10", "report on b", int'(reportValue), b);
        scan(W'(c));
        checkEq("R4", "pending on c", int'(pending), 1);
        if (chg) begin
          checkEq("R4", "frozen report", int'(reportValue), b);
          checkEq("R8", "no rewake", int'(wakeReq), 0);
        end else begin
          checkEq("R4", "report on c", int'(reportValue), c);
          checkEq("R7", "wake on c", int'(wakeReq), 1);
        end
        rd();
        checkEq("R5", "cleared", int'(pending), 0);
        checkEq("R5", "report = sample", int'(reportValue), c);
      end
    end

    // R5: read colliding with a differing scan
    scan(4'd2);
    rd();
    cyc(1'b1, 4'd7, 1'b1, 1'b0);
    checkEq("R5", "collide pending", int'(pending), 1);
    checkEq("R5", "collide report", int'(reportValue), 7);
    scan(4'd7);
    checkEq("R5", "collide still held", int'(reportValue), 7);

    // R8: sleep rearms wake
    rd();
    scan(4'd1);
    checkEq("R7", "wake fires", int'(wakeReq), 1);
    rd();
    scan(4'd2);
    checkEq("R8", "read rearmed", int'(wakeReq), 1);
    scan(4'd4);
    checkEq("R8", "disarmed", int'(wakeReq), 0);
    cyc(1'b0, '0, 1'b0, 1'b1);
    scan(4'd8);
    checkEq("R8", "sleep rearmed", int'(wakeReq), 1);

    // R9: wake disabled
    wakeEn = 1'b0;
    rd();
    for (int v = 0; v < NV; v++) begin
      scan(W'(v));
      checkEq("R9", "no wake", int'(wakeReq), 0);
      rd();
    end

    // R6: capture off is transparent
    capEn = 1'b0;
    wakeEn = 1'b1;
    rd();
    for (int v = 0; v < NV; v++) begin
      scan(W'(v));
      checkEq("R6", "report", int'(reportValue), v);
      checkEq("R6", "pending", int'(pending), 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule